// File: doc/BRIEF.md
# Control-Transfer Instruction Classifier

This block looks at each instruction as it retires from a RV32 or RV64 hart and produces the termination-type code that an instruction trace encoder needs. It decodes both full 32-bit and compressed instruction words. Two flags come from the execution pipeline: whether a conditional branch was taken, and whether the instruction is a trap return. With these flags the block separates branches, trap returns, calls, plain jumps, returns, co-routine swaps and other jumps. It also marks each jump as inferable or uninferable. It applies the calling-convention rules on the link registers x1 and x5.

The block also raises a flag for an uninferable jump when the instruction that retired just before it was a lui, auipc or c.lui that wrote the jump's source register. This is called a sequentially inferable jump, and the encoder can treat it as inferable. A small register remembers whether the previous retired instruction loaded a constant, and which register it wrote. A parameter selects a full 4-bit type output or a reduced 3-bit one. The type code and the flag are combinational from the current retirement, so they line up with the rest of the trace inputs in the same cycle.

Top module: `cti_classifier`

## Requirements
- R1: After reset the remembered constant-load state is empty, so the first jump retired after reset (jalr x0,x6) gives type 10 and a low sequential flag, even if a lui x6 was on the bus during reset.
- R2: A retired conditional branch gives type 5 when br_taken_i is high and type 4 when it is low. This covers 32-bit opcode 1100011 and compressed quadrant 01 with funct3 110 or 111.
- R3: When retire_i and xret_i are both high, the type is 3, whatever the instruction word holds.
- R4: Jumps whose target is an immediate in the opcode are inferable. jal with rd x1 or x5 gives 9, jal x0 gives 11, and jal with any other rd gives 15. Compressed c.j (funct3 101, quadrant 01) gives 11, and c.jal (funct3 001, quadrant 01, only when XLEN is 32) gives 9.
- R5: Uninferable calls give type 8: jalr x1 with rs1 not x5, jalr x5 with rs1 not x1, and c.jalr (funct4 1001, quadrant 10, rs2 zero) with rs1 not x5.
- R6: Uninferable plain jumps give type 10: jalr x0 with rs1 neither x1 nor x5, and c.jr (funct4 1000, quadrant 10, rs2 zero) with rs1 neither x1 nor x5.
- R7: Returns give type 13: a jalr whose rs1 is x1 or x5 and whose rd is neither x1 nor x5, and c.jr with rs1 x1 or x5.
- R8: Co-routine swaps give type 12: jalr x1,x5, jalr x5,x1 and c.jalr x5.
- R9: A jalr whose rd is not x0, x1 or x5 and whose rs1 is neither x1 nor x5 gives type 14.
- R10: With the 3-bit output, types 8, 10, 12, 13 and 14 become 6, types 9, 11 and 15 become 0, and types 3, 4 and 5 stay the same.
- R11: The sequential flag is high only when three things hold. The previous retired instruction was lui (0110111), auipc (0010111) or c.lui (funct3 011, quadrant 01), and it had a non-zero rd. That rd equals the current jump's rs1. The current output type is 6, 8, 10, 12 or 14. A return (type 13) in 4-bit mode and any inferable jump never raise the flag.
- R12: A cycle with retire_i low, or a retiring cycle with trap_i high, clears the remembered constant load. The next jump then has a low sequential flag.
- R13: While retire_i is low, the type output is 0 and the sequential flag is low.
- R14: Any retired instruction that is not a branch, a jump or a trap return gives type 0, and the block never produces types 1, 2 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An instruction retires this cycle |
| insn_i | input | 32 | Retired instruction word; a compressed word sits in bits 15:0 |
| br_taken_i | input | 1 | Conditional branch outcome for this retirement |
| xret_i | input | 1 | The retired instruction is a trap return |
| trap_i | input | 1 | A trap is taken in this cycle |
| itype_o | output | TYPE_W | Termination type code |
| sijump_o | output | 1 | Jump is sequentially inferable |

## Verification
A wrong type decode shows at itype_o in the same cycle the instruction retires, because the path from insn_i to the output has no register. The only internal state is the remembered constant-load destination. If it is wrong, the fault appears only one retirement later, as a wrong sijump_o on the jump that follows. The stimulus therefore always pairs a chosen predecessor with the jump under test, including mismatched registers, bubbles and trap cycles between them. Both output widths are compared on every pair.

// File: rtl/cti_pkg.sv
package cti_pkg;

  localparam int REG_W = 5;

  localparam logic [3:0] CT_NONE   = 4'd0;
  localparam logic [3:0] CT_XRET   = 4'd3;
  localparam logic [3:0] CT_BR_NT  = 4'd4;
  localparam logic [3:0] CT_BR_TK  = 4'd5;
  localparam logic [3:0] CT_UJ_N   = 4'd6;
  localparam logic [3:0] CT_CALL_U = 4'd8;
  localparam logic [3:0] CT_CALL_I = 4'd9;
  localparam logic [3:0] CT_JMP_U  = 4'd10;
  localparam logic [3:0] CT_JMP_I  = 4'd11;
  localparam logic [3:0] CT_SWAP   = 4'd12;
  localparam logic [3:0] CT_RET    = 4'd13;
  localparam logic [3:0] CT_OTH_U  = 4'd14;
  localparam logic [3:0] CT_OTH_I  = 4'd15;

  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_JALR   = 7'b1100111;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_LUI    = 7'b0110111;
  localparam logic [6:0] OP_AUIPC  = 7'b0010111;

  function automatic logic is_link(input logic [REG_W-1:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

  // Calling-convention split of a jump given its effective rd / rs1.
  function automatic logic [3:0] classify_jump(input logic indirect,
                                               input logic [REG_W-1:0] rd,
                                               input logic [REG_W-1:0] rs);
    logic lrd, lrs, swap, call, ret, jmp;
    lrd  = is_link(rd);
    lrs  = indirect && is_link(rs);
    swap = lrd && lrs && (rd != rs);
    call = lrd && !swap;
    ret  = lrs && !lrd;
    jmp  = (rd == '0) && !lrs;
    if (call)      return indirect ? CT_CALL_U : CT_CALL_I;
    else if (jmp)  return indirect ? CT_JMP_U  : CT_JMP_I;
    else if (ret)  return CT_RET;
    else if (swap) return CT_SWAP;
    else           return indirect ? CT_OTH_U  : CT_OTH_I;
  endfunction

endpackage

// File: rtl/cti_decode.sv
module cti_decode
  import cti_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]      insn_i,
  input  logic             br_taken_i,
  input  logic             xret_i,
  output logic [3:0]       code_o,
  output logic             ld_hit_o,
  output logic [REG_W-1:0] ld_rd_o,
  output logic [REG_W-1:0] jmp_rs_o
);

  logic             is_rvc;
  logic [6:0]       op;
  logic [2:0]       f3;
  logic [REG_W-1:0] rd, rs1;
  logic [2:0]       cf3;
  logic [REG_W-1:0] crd, crs2;
  logic             j_dir, j_ind, br;
  logic [REG_W-1:0] rd_e, rs_e;
  logic             unused_bits;

  assign is_rvc = (insn_i[1:0] != 2'b11);
  assign op     = insn_i[6:0];
  assign f3     = insn_i[14:12];
  assign rd     = insn_i[11:7];
  assign rs1    = insn_i[19:15];
  assign cf3    = insn_i[15:13];
  assign crd    = insn_i[11:7];
  assign crs2   = insn_i[6:2];
  assign unused_bits = ^insn_i[31:20];

  always_comb begin
    j_dir    = 1'b0;
    j_ind    = 1'b0;
    br       = 1'b0;
    rd_e     = '0;
    rs_e     = '0;
    ld_hit_o = 1'b0;
    ld_rd_o  = '0;
    if (!is_rvc) begin
      unique case (op)
        OP_JAL: begin
          j_dir = 1'b1;
          rd_e  = rd;
        end
        OP_JALR: begin
          if (f3 == 3'b000) begin
            j_ind = 1'b1;
            rd_e  = rd;
            rs_e  = rs1;
          end
        end
        OP_BRANCH: br = (f3 != 3'b010) && (f3 != 3'b011);
        OP_LUI, OP_AUIPC: begin
          ld_hit_o = 1'b1;
          ld_rd_o  = rd;
        end
        default: ;
      endcase
    end else if (insn_i[1:0] == 2'b01) begin
      unique case (cf3)
        3'b101: j_dir = 1'b1;
        3'b001: begin
          if (XLEN == 32) begin
            j_dir = 1'b1;
            rd_e  = 5'd1;
          end
        end
        3'b110, 3'b111: br = 1'b1;
        3'b011: begin
          if ((crd != 5'd0) && (crd != 5'd2)) begin
            ld_hit_o = 1'b1;
            ld_rd_o  = crd;
          end
        end
        default: ;
      endcase
    end else if (insn_i[1:0] == 2'b10) begin
      if ((cf3 == 3'b100) && (crs2 == '0) && (crd != '0)) begin
        j_ind = 1'b1;
        rs_e  = crd;
        rd_e  = insn_i[12] ? 5'd1 : 5'd0;
      end
    end
  end

  always_comb begin
    if (xret_i)              code_o = CT_XRET;
    else if (br)             code_o = br_taken_i ? CT_BR_TK : CT_BR_NT;
    else if (j_dir || j_ind) code_o = classify_jump(j_ind, rd_e, rs_e);
    else                     code_o = CT_NONE;
  end

  assign jmp_rs_o = rs_e;

endmodule

// File: rtl/cti_prev_track.sv
module cti_prev_track
  import cti_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             trap_i,
  input  logic             ld_hit_i,
  input  logic [REG_W-1:0] ld_rd_i,
  output logic             prev_vld_o,
  output logic [REG_W-1:0] prev_rd_o
);

  logic             vld_q, vld_d;
  logic [REG_W-1:0] rd_q;
  logic             rd_en;

  always_comb begin
    rd_en = retire_i && !trap_i && ld_hit_i && (ld_rd_i != '0);
    vld_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (rd_en) rd_q <= ld_rd_i;
    end
  end

  assign prev_vld_o = vld_q;
  assign prev_rd_o  = rd_q;

  AST_STATE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i || trap_i) |=> !prev_vld_o); // R12

endmodule

// File: rtl/cti_code_map.sv
module cti_code_map
  import cti_pkg::*;
#(
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic [3:0]        code_i,
  input  logic              prev_vld_i,
  input  logic [REG_W-1:0]  prev_rd_i,
  input  logic [REG_W-1:0]  jmp_rs_i,
  output logic [TYPE_W-1:0] itype_o,
  output logic              sijump_o
);

  logic              match;
  logic [TYPE_W-1:0] mapped;
  logic              elig;

  assign match = prev_vld_i && (prev_rd_i == jmp_rs_i);

  generate
    if (TYPE_W == 3) begin : g_narrow
      logic infer;
      always_comb begin
        infer = (code_i == CT_CALL_I) || (code_i == CT_JMP_I) || (code_i == CT_OTH_I);
        if (code_i[3])  mapped = infer ? 3'd0 : CT_UJ_N[2:0];
        else            mapped = code_i[2:0];
        elig = (mapped == CT_UJ_N[2:0]);
      end

      AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |-> (itype_o != 3'd7)); // R10
    end else begin : g_wide
      always_comb begin
        mapped = code_i;
        elig   = (mapped == CT_CALL_U) || (mapped == CT_JMP_U) ||
                 (mapped == CT_SWAP)   || (mapped == CT_OTH_U);
      end
    end
  endgenerate

  assign itype_o  = retire_i ? mapped : '0;
  assign sijump_o = retire_i && elig && match;

endmodule

// File: rtl/cti_classifier.sv
module cti_classifier
  import cti_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic [31:0]       insn_i,
  input  logic              br_taken_i,
  input  logic              xret_i,
  input  logic              trap_i,
  output logic [TYPE_W-1:0] itype_o,
  output logic              sijump_o
);

  logic [3:0]       code;
  logic             ld_hit;
  logic [REG_W-1:0] ld_rd, jmp_rs, prev_rd;
  logic             prev_vld;

  cti_decode #(.XLEN(XLEN)) u_dec (
    .insn_i    (insn_i),
    .br_taken_i(br_taken_i),
    .xret_i    (xret_i),
    .code_o    (code),
    .ld_hit_o  (ld_hit),
    .ld_rd_o   (ld_rd),
    .jmp_rs_o  (jmp_rs)
  );

  cti_prev_track u_prev (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire_i  (retire_i),
    .trap_i    (trap_i),
    .ld_hit_i  (ld_hit),
    .ld_rd_i   (ld_rd),
    .prev_vld_o(prev_vld),
    .prev_rd_o (prev_rd)
  );

  cti_code_map #(.TYPE_W(TYPE_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire_i  (retire_i),
    .code_i    (code),
    .prev_vld_i(prev_vld),
    .prev_rd_i (prev_rd),
    .jmp_rs_i  (jmp_rs),
    .itype_o   (itype_o),
    .sijump_o  (sijump_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |-> (itype_o == '0) && !sijump_o); // R13
  AST_XRET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && xret_i) |-> (itype_o == TYPE_W'(3))); // R3
  AST_SIJ_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    sijump_o |-> $past(retire_i && !trap_i)); // R12
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |-> !(code inside {4'd1, 4'd2, 4'd6, 4'd7})); // R14

endmodule

// File: tb/tb_cti_classifier.sv
module tb_cti_classifier;

  localparam int PERIOD = 8;

  function automatic logic [31:0] e_jal(int rd);
    return (32'(rd) << 7) | 32'h6F;
  endfunction
  function automatic logic [31:0] e_jalr(int rd, int rs);
    return (32'(rs) << 15) | (32'(rd) << 7) | 32'h67;
  endfunction
  function automatic logic [31:0] e_lui(int rd);
    return (32'(rd) << 7) | 32'h1037;
  endfunction
  function automatic logic [31:0] e_aui(int rd);
    return (32'(rd) << 7) | 32'h1017;
  endfunction
  function automatic logic [31:0] c_jr(int rs);
    return (32'(rs) << 7) | 32'h8002;
  endfunction
  function automatic logic [31:0] c_jalr(int rs);
    return (32'(rs) << 7) | 32'h9002;
  endfunction
  function automatic logic [31:0] c_lui(int rd);
    return (32'(rd) << 7) | 32'h6005;
  endfunction

  localparam logic [31:0] NOP    = 32'h0000_0013;
  localparam logic [31:0] BEQ    = 32'h0000_0063;
  localparam logic [31:0] MRET   = 32'h3020_0073;
  localparam logic [31:0] C_J    = 32'h0000_A001;
  localparam logic [31:0] C_JAL  = 32'h0000_2001;
  localparam logic [31:0] C_BEQZ = 32'h0000_C001;
  localparam logic [31:0] C_BNEZ = 32'h0000_E001;

  typedef struct packed {
    logic [31:0] pre;
    logic [31:0] ins;
    logic        tk;
    logic        xr;
    logic [3:0]  e4;
    logic        mt;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VT [NV] = '{
    '{NOP, BEQ,          1'b0, 1'b0, 4'd4,  1'b0, 4'd2},  // R2
    '{NOP, BEQ,          1'b1, 1'b0, 4'd5,  1'b0, 4'd2},  // R2
    '{NOP, C_BNEZ,       1'b1, 1'b0, 4'd5,  1'b0, 4'd2},  // R2
    '{NOP, C_BEQZ,       1'b0, 1'b0, 4'd4,  1'b0, 4'd2},  // R2
    '{NOP, MRET,         1'b0, 1'b1, 4'd3,  1'b0, 4'd3},  // R3
    '{NOP, BEQ,          1'b1, 1'b1, 4'd3,  1'b0, 4'd3},  // R3 priority
    '{NOP, e_jal(1),     1'b0, 1'b0, 4'd9,  1'b0, 4'd4},  // R4
    '{NOP, e_jal(5),     1'b0, 1'b0, 4'd9,  1'b0, 4'd4},  // R4
    '{NOP, e_jal(0),     1'b0, 1'b0, 4'd11, 1'b0, 4'd4},  // R4
    '{NOP, e_jal(7),     1'b0, 1'b0, 4'd15, 1'b0, 4'd4},  // R4
    '{NOP, C_JAL,        1'b0, 1'b0, 4'd9,  1'b0, 4'd4},  // R4
    '{NOP, C_J,          1'b0, 1'b0, 4'd11, 1'b0, 4'd4},  // R4
    '{NOP, e_jalr(1,6),  1'b0, 1'b0, 4'd8,  1'b0, 4'd5},  // R5
    '{NOP, e_jalr(5,0),  1'b0, 1'b0, 4'd8,  1'b0, 4'd5},  // R5
    '{NOP, c_jalr(6),    1'b0, 1'b0, 4'd8,  1'b0, 4'd5},  // R5
    '{NOP, e_jalr(0,6),  1'b0, 1'b0, 4'd10, 1'b0, 4'd6},  // R6
    '{NOP, c_jr(6),      1'b0, 1'b0, 4'd10, 1'b0, 4'd6},  // R6
    '{NOP, e_jalr(0,1),  1'b0, 1'b0, 4'd13, 1'b0, 4'd7},  // R7
    '{NOP, c_jr(5),      1'b0, 1'b0, 4'd13, 1'b0, 4'd7},  // R7
    '{NOP, e_jalr(6,5),  1'b0, 1'b0, 4'd13, 1'b0, 4'd7},  // R7
    '{NOP, e_jalr(1,5),  1'b0, 1'b0, 4'd12, 1'b0, 4'd8},  // R8
    '{NOP, e_jalr(5,1),  1'b0, 1'b0, 4'd12, 1'b0, 4'd8},  // R8
    '{NOP, c_jalr(5),    1'b0, 1'b0, 4'd12, 1'b0, 4'd8},  // R8
    '{NOP, e_jalr(7,6),  1'b0, 1'b0, 4'd14, 1'b0, 4'd9},  // R9
    '{e_lui(6), e_jalr(0,6), 1'b0, 1'b0, 4'd10, 1'b1, 4'd11}, // R11
    '{e_aui(6), e_jalr(1,6), 1'b0, 1'b0, 4'd8,  1'b1, 4'd11}, // R11
    '{c_lui(6), c_jr(6),     1'b0, 1'b0, 4'd10, 1'b1, 4'd11}, // R11
    '{e_lui(7), e_jalr(0,6), 1'b0, 1'b0, 4'd10, 1'b0, 4'd11}, // R11 rd mismatch
    '{e_lui(1), e_jalr(0,1), 1'b0, 1'b0, 4'd13, 1'b1, 4'd11}, // R11 return
    '{e_lui(6), e_jal(1),    1'b0, 1'b0, 4'd9,  1'b1, 4'd11}, // R11 inferable
    '{e_lui(6), e_jalr(7,6), 1'b0, 1'b0, 4'd14, 1'b1, 4'd11}, // R11
    '{e_lui(6), NOP,         1'b0, 1'b0, 4'd0,  1'b1, 4'd14}  // R14
  };

  logic        clk, rst_n, retire, br_taken, xret, trap;
  logic [31:0] insn;
  logic [3:0]  itype_w;
  logic [2:0]  itype_n;
  logic        sij_w, sij_n;
  int          n_cmp, n_bad;

  cti_classifier #(.XLEN(32), .TYPE_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .insn_i(insn),
    .br_taken_i(br_taken), .xret_i(xret), .trap_i(trap),
    .itype_o(itype_w), .sijump_o(sij_w)
  );

  cti_classifier #(.XLEN(32), .TYPE_W(3)) dut_n (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .insn_i(insn),
    .br_taken_i(br_taken), .xret_i(xret), .trap_i(trap),
    .itype_o(itype_n), .sijump_o(sij_n)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic logic [2:0] narrow(logic [3:0] c);
    if (!c[3]) return c[2:0];
    if (c == 4'd9 || c == 4'd11 || c == 4'd15) return 3'd0;
    return 3'd6;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic r, logic [31:0] i, logic tk, logic xr, logic tp);
    @(negedge clk);
    retire = r; insn = i; br_taken = tk; xret = xr; trap = tp;
    #2;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; retire = 1'b1; insn = e_lui(6);
    br_taken = 1'b0; xret = 1'b0; trap = 1'b0;
    repeat (3) @(posedge clk);
    // R1: state empty right after reset
    @(negedge clk);
    rst_n = 1'b1; insn = e_jalr(0, 6);
    #2;
    chk("R1 wide type", int'(itype_w), 10);
    chk("R1 wide sij", int'(sij_w), 0);
    chk("R1 narrow sij", int'(sij_n), 0);

    for (int k = 0; k < NV; k++) begin
      logic e_sw, e_sn;
      logic [2:0] en;
      drive(1'b1, VT[k].pre, 1'b0, 1'b0, 1'b0);
      drive(1'b1, VT[k].ins, VT[k].tk, VT[k].xr, 1'b0);
      en   = narrow(VT[k].e4);
      e_sw = VT[k].mt && (VT[k].e4 inside {4'd8, 4'd10, 4'd12, 4'd14});
      e_sn = VT[k].mt && (en == 3'd6);
      chk($sformatf("R%0d wide type v%0d", VT[k].rq, k), int'(itype_w), int'(VT[k].e4));
      chk($sformatf("R10 narrow type v%0d", k), int'(itype_n), int'(en));
      chk($sformatf("R11 wide sij v%0d", k), int'(sij_w), int'(e_sw));
      chk($sformatf("R11 narrow sij v%0d", k), int'(sij_n), int'(e_sn));
    end

    // R12: bubble between lui and jump clears state
    drive(1'b1, e_lui(6), 1'b0, 1'b0, 1'b0);
    drive(1'b0, NOP, 1'b0, 1'b0, 1'b0);
    drive(1'b1, e_jalr(0, 6), 1'b0, 1'b0, 1'b0);
    chk("R12 bubble wide sij", int'(sij_w), 0);
    chk("R12 bubble narrow sij", int'(sij_n), 0);
    // R12: trap on the lui cycle clears state
    drive(1'b1, e_lui(6), 1'b0, 1'b0, 1'b1);
    drive(1'b1, e_jalr(0, 6), 1'b0, 1'b0, 1'b0);
    chk("R12 trap wide sij", int'(sij_w), 0);
    chk("R12 trap type", int'(itype_w), 10);
    // R11 positive control right after, same pair without trap
    drive(1'b1, e_lui(6), 1'b0, 1'b0, 1'b0);
    drive(1'b1, e_jalr(0, 6), 1'b0, 1'b0, 1'b0);
    chk("R11 control wide sij", int'(sij_w), 1);
    // R13: idle cycle with a jump on the bus, after a lui
    drive(1'b1, e_lui(6), 1'b0, 1'b0, 1'b0);
    drive(1'b0, e_jalr(0, 6), 1'b1, 1'b1, 1'b0);
    chk("R13 wide type", int'(itype_w), 0);
    chk("R13 narrow type", int'(itype_n), 0);
    chk("R13 wide sij", int'(sij_w), 0);
    chk("R13 narrow sij", int'(sij_n), 0);

    drive(1'b0, NOP, 1'b0, 1'b0, 1'b0);
    summary();
  end

endmodule